// File: doc/BRIEF.md
# Conversion Slot Trigger Scheduler

This block sits between the trigger sources of a chip and a single shared analogue-to-digital converter. It holds a bank of conversion slots. Each slot names one trigger source, one input channel and one sample-window length. Hardware strobes, a software force write and two end-of-conversion flags all turn into pending requests. The block keeps one request flag per slot. It offers the lowest-numbered pending slot to the conversion controller and drops that flag once the controller accepts it.

A single trigger can fan out to many slots. This builds a conversion sequence, or repeated samples of one channel when the slots share a channel. The end-of-conversion flags can re-arm slots, which gives continuous conversion. The idle output tells the surrounding logic when resolution or signal mode may be changed safely: no slot is pending and the converter is not busy.

Top module: `adc_soc_sched`

## Requirements
- R1: After reset, no slot is pending, every overflow bit is 0, `req_valid` is 0 and `idle` is 1. Every slot's trigger code is 0 (software only), so hardware strobes queue nothing.
- R2: A cycle with `force_we` high sets slot n pending for every set bit n of `force_bits`, whatever trigger code that slot holds. The slot appears at the request outputs from the next cycle on.
- R3: Hardware trigger codes are as follows. Code 0 means software only. Codes 1 to 3 are timer strobes 0 to 2. Code 4 is the GPIO strobe. Code 5+2k is start pulse A of PWM source k, and code 6+2k is start pulse B of that source. Unused codes never match. A one-cycle strobe sets pending, in that cycle, every slot whose code selects it.
- R4: The 2-bit re-arm field of a slot works as follows. 0 means none, 1 means end-of-conversion flag 1, 2 means flag 2, and 3 means either flag. A strobe on a selected flag sets the slot pending.
- R5: While any slot is pending, `req_valid` is 1 and `req_slot` is the lowest-numbered pending slot. `req_chan` and `req_win` carry that slot's configured channel and window.
- R6: A cycle with `req_valid` and `req_ready` both high clears the offered slot's pending flag. The next pending slot is offered in the following cycle.
- R7: A trigger that reaches a slot that is already pending merges with the open request. After any number of such triggers, the slot is offered exactly once.
- R8: The overflow bit of a slot becomes 1 when a trigger reaches the slot while it is pending and not being accepted in that cycle. The bit then stays 1 until reset.
- R9: `idle` is 1 exactly when no slot is pending and `conv_busy` is 0.
- R10: A trigger for a slot in the same cycle in which that slot is accepted queues it again. It does not set the slot's overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one slot's configuration |
| cfg_slot | input | SLOT_W | Slot being configured |
| cfg_trig | input | TRIG_W | Trigger code for the slot |
| cfg_chan | input | CH_W | Channel number for the slot |
| cfg_win | input | WIN_W | Sample-window length for the slot |
| cfg_rearm | input | 2 | End-of-conversion re-arm select |
| tmr_stb | input | 3 | Timer trigger strobes |
| gpio_stb | input | 1 | External GPIO trigger strobe |
| pwm_a_stb | input | NUM_PWM | Start pulse A per PWM source |
| pwm_b_stb | input | NUM_PWM | Start pulse B per PWM source |
| force_we | input | 1 | Software force write strobe |
| force_bits | input | NUM_SLOTS | Slots to force pending |
| eoc1_stb | input | 1 | End-of-conversion flag 1 set strobe |
| eoc2_stb | input | 1 | End-of-conversion flag 2 set strobe |
| conv_busy | input | 1 | Converter is working on a slot |
| req_ready | input | 1 | Controller accepts the offered slot |
| req_valid | output | 1 | A slot is offered |
| req_slot | output | SLOT_W | Offered slot number |
| req_chan | output | CH_W | Offered slot's channel |
| req_win | output | WIN_W | Offered slot's sample window |
| idle | output | 1 | Nothing pending and converter idle |
| ovf | output | NUM_SLOTS | Sticky overflow bit per slot |

## Verification
The bench builds the block with sixteen slots and two PWM sources. This leaves nine defined trigger codes inside a 4-bit code field. Each of the sixteen slots can then hold a different code, so one strobe sweep covers every code, including the seven unused ones. A second sweep shares timer codes across slots, and a third spreads all four re-arm selections over the slots. Together these cover fan-out and priority ordering. Directed sequences cover merged triggers, overflow, a trigger in the accept cycle and the idle conditions.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

    // Timer strobes take codes 1..NUM_TMR, then GPIO, then PWM A/B pairs.
    localparam int NUM_TMR      = 3;
    localparam int CODE_SW_ONLY = 0;

    typedef enum logic [1:0] {
        REARM_NONE   = 2'd0,
        REARM_EOC1   = 2'd1,
        REARM_EOC2   = 2'd2,
        REARM_EITHER = 2'd3
    } rearm_e;

    // Number of hardware strobe lines for a given PWM source count.
    function automatic int hw_count(input int num_pwm);
        return NUM_TMR + 1 + 2 * num_pwm;
    endfunction

    function automatic logic rearm_hit(input rearm_e sel, input logic e1, input logic e2);
        logic r;
        case (sel)
            REARM_EOC1:   r = e1;
            REARM_EOC2:   r = e2;
            REARM_EITHER: r = e1 | e2;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_slot_cfg.sv
module adc_slot_cfg
    import adc_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int TRIG_W    = 4,
    parameter int CH_W      = 4,
    parameter int WIN_W     = 9,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [TRIG_W-1:0] trig,
    input  logic [CH_W-1:0]   chan,
    input  logic [WIN_W-1:0]  win,
    input  logic [1:0]        rearm,
    output logic [TRIG_W-1:0] trig_q  [NUM_SLOTS],
    output logic [CH_W-1:0]   chan_q  [NUM_SLOTS],
    output logic [WIN_W-1:0]  win_q   [NUM_SLOTS],
    output rearm_e            rearm_q [NUM_SLOTS]
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                trig_q[g]  <= TRIG_W'(CODE_SW_ONLY);
                chan_q[g]  <= '0;
                win_q[g]   <= '0;
                rearm_q[g] <= REARM_NONE;
            end else if (we && slot == SLOT_W'(g)) begin
                trig_q[g]  <= trig;
                chan_q[g]  <= chan;
                win_q[g]   <= win;
                rearm_q[g] <= rearm_e'(rearm);
            end
        end
    end

endmodule

// File: rtl/adc_slot_hit.sv
module adc_slot_hit
    import adc_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int TRIG_W    = 4,
    parameter int NUM_HW    = 8
) (
    input  logic [TRIG_W-1:0]    trig_q  [NUM_SLOTS],
    input  rearm_e               rearm_q [NUM_SLOTS],
    input  logic [NUM_HW-1:0]    hw_stb,
    input  logic                 force_we,
    input  logic [NUM_SLOTS-1:0] force_bits,
    input  logic                 eoc1_stb,
    input  logic                 eoc2_stb,
    output logic [NUM_SLOTS-1:0] hit
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hw_hit;
        always_comb begin
            hw_hit = 1'b0;
            for (int i = 0; i < NUM_HW; i++) begin
                if (trig_q[g] == TRIG_W'(i + 1)) hw_hit = hw_stb[i];
            end
        end
        assign hit[g] = hw_hit
                      | (force_we & force_bits[g])
                      | rearm_hit(rearm_q[g], eoc1_stb, eoc2_stb);
    end

endmodule

// File: rtl/adc_pick_lowest.sv
module adc_pick_lowest #(
    parameter int N       = 16,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any   = |req;
    assign grant = req & (~req + N'(1));

endmodule

// File: rtl/adc_soc_sched.sv
module adc_soc_sched
    import adc_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_PWM   = 4,
    parameter int CH_W      = 4,
    parameter int WIN_W     = 9,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int NUM_HW   = hw_count(NUM_PWM),
    localparam int TRIG_W   = $clog2(NUM_HW + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [TRIG_W-1:0]    cfg_trig,
    input  logic [CH_W-1:0]      cfg_chan,
    input  logic [WIN_W-1:0]     cfg_win,
    input  logic [1:0]           cfg_rearm,
    input  logic [NUM_TMR-1:0]   tmr_stb,
    input  logic                 gpio_stb,
    input  logic [NUM_PWM-1:0]   pwm_a_stb,
    input  logic [NUM_PWM-1:0]   pwm_b_stb,
    input  logic                 force_we,
    input  logic [NUM_SLOTS-1:0] force_bits,
    input  logic                 eoc1_stb,
    input  logic                 eoc2_stb,
    input  logic                 conv_busy,
    input  logic                 req_ready,
    output logic                 req_valid,
    output logic [SLOT_W-1:0]    req_slot,
    output logic [CH_W-1:0]      req_chan,
    output logic [WIN_W-1:0]     req_win,
    output logic                 idle,
    output logic [NUM_SLOTS-1:0] ovf
);

    logic [TRIG_W-1:0]    trig_q  [NUM_SLOTS];
    logic [CH_W-1:0]      chan_q  [NUM_SLOTS];
    logic [WIN_W-1:0]     win_q   [NUM_SLOTS];
    rearm_e               rearm_q [NUM_SLOTS];
    logic [NUM_HW-1:0]    hw_stb;
    logic [NUM_SLOTS-1:0] hit, grant, accept;
    logic [NUM_SLOTS-1:0] pend_q, ovf_q;

    // Strobe line i answers to trigger code i+1.
    always_comb begin
        hw_stb = '0;
        hw_stb[NUM_TMR-1:0] = tmr_stb;
        hw_stb[NUM_TMR]     = gpio_stb;
        for (int k = 0; k < NUM_PWM; k++) begin
            hw_stb[NUM_TMR + 1 + 2 * k]     = pwm_a_stb[k];
            hw_stb[NUM_TMR + 1 + 2 * k + 1] = pwm_b_stb[k];
        end
    end

    adc_slot_cfg #(
        .NUM_SLOTS(NUM_SLOTS), .TRIG_W(TRIG_W), .CH_W(CH_W), .WIN_W(WIN_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .slot(cfg_slot), .trig(cfg_trig),
        .chan(cfg_chan), .win(cfg_win), .rearm(cfg_rearm),
        .trig_q(trig_q), .chan_q(chan_q), .win_q(win_q), .rearm_q(rearm_q)
    );

    adc_slot_hit #(
        .NUM_SLOTS(NUM_SLOTS), .TRIG_W(TRIG_W), .NUM_HW(NUM_HW)
    ) u_hit (
        .trig_q(trig_q), .rearm_q(rearm_q), .hw_stb(hw_stb),
        .force_we(force_we), .force_bits(force_bits),
        .eoc1_stb(eoc1_stb), .eoc2_stb(eoc2_stb), .hit(hit)
    );

    adc_pick_lowest #(.N(NUM_SLOTS)) u_pick (
        .req(pend_q), .any(req_valid), .idx(req_slot), .grant(grant)
    );

    assign accept = (req_valid && req_ready) ? grant : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ovf_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~accept) | hit;
            ovf_q  <= ovf_q | (hit & pend_q & ~accept);
        end
    end

    assign req_chan = chan_q[req_slot];
    assign req_win  = win_q[req_slot];
    assign idle     = ~(|pend_q) & ~conv_busy;
    assign ovf      = ovf_q;

endmodule

// File: rtl/adc_soc_sched_chk.sv
module adc_soc_sched_chk #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 force_we,
    input logic [NUM_SLOTS-1:0] force_bits,
    input logic                 conv_busy,
    input logic                 req_valid,
    input logic [SLOT_W-1:0]    req_slot,
    input logic                 idle,
    input logic [NUM_SLOTS-1:0] ovf,
    input logic [NUM_SLOTS-1:0] pend
);

    logic [NUM_SLOTS-1:0] below;
    always_comb below = (NUM_SLOTS'(1) << req_slot) - NUM_SLOTS'(1);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!req_valid && ovf == '0 && pend == '0));

    p_force_queues_r2: assert property (@(posedge clk) disable iff (rst)
        (force_we && force_bits != '0) |=> req_valid);

    p_lowest_first_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (pend[req_slot] && (pend & below) == '0));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!req_valid && !conv_busy));

endmodule

bind adc_soc_sched adc_soc_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .force_we(force_we), .force_bits(force_bits),
    .conv_busy(conv_busy), .req_valid(req_valid), .req_slot(req_slot),
    .idle(idle), .ovf(ovf), .pend(pend_q)
);

// File: tb/sim_adc_soc_sched.sv
`timescale 1ns/1ps
module sim_adc_soc_sched;

    localparam int NS   = 16;
    localparam int NPWM = 2;
    localparam int CW   = 4;
    localparam int WW   = 9;
    localparam int SW   = 4;
    localparam int TW   = 4;
    localparam int NHW  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_we = 0;
    logic [SW-1:0] cfg_slot = 0;
    logic [TW-1:0] cfg_trig = 0;
    logic [CW-1:0] cfg_chan = 0;
    logic [WW-1:0] cfg_win = 0;
    logic [1:0] cfg_rearm = 0;
    logic [2:0] tmr_stb = 0;
    logic gpio_stb = 0;
    logic [NPWM-1:0] pwm_a_stb = 0, pwm_b_stb = 0;
    logic force_we = 0;
    logic [NS-1:0] force_bits = 0;
    logic eoc1_stb = 0, eoc2_stb = 0;
    logic conv_busy = 0, req_ready = 0;
    logic req_valid, idle;
    logic [SW-1:0] req_slot;
    logic [CW-1:0] req_chan;
    logic [WW-1:0] req_win;
    logic [NS-1:0] ovf;

    adc_soc_sched #(.NUM_SLOTS(NS), .NUM_PWM(NPWM), .CH_W(CW), .WIN_W(WW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_trig(cfg_trig), .cfg_chan(cfg_chan), .cfg_win(cfg_win),
        .cfg_rearm(cfg_rearm), .tmr_stb(tmr_stb), .gpio_stb(gpio_stb),
        .pwm_a_stb(pwm_a_stb), .pwm_b_stb(pwm_b_stb), .force_we(force_we),
        .force_bits(force_bits), .eoc1_stb(eoc1_stb), .eoc2_stb(eoc2_stb),
        .conv_busy(conv_busy), .req_ready(req_ready), .req_valid(req_valid),
        .req_slot(req_slot), .req_chan(req_chan), .req_win(req_win),
        .idle(idle), .ovf(ovf)
    );

    int n_chk = 0, n_fail = 0;
    logic [CW-1:0] exp_chan [NS];
    logic [WW-1:0] exp_win  [NS];
    logic [NS-1:0] d_mask;
    int d_cnt;
    logic d_order, d_data;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int s = 0; s < NS; s++) begin exp_chan[s] = 0; exp_win[s] = 0; end
    endtask

    task automatic write_cfg(input int s, input int trig, input int ch, input int win, input int rearm);
        @(negedge clk);
        cfg_we = 1; cfg_slot = SW'(s); cfg_trig = TW'(trig);
        cfg_chan = CW'(ch); cfg_win = WW'(win); cfg_rearm = 2'(rearm);
        exp_chan[s] = CW'(ch); exp_win[s] = WW'(win);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Line i: 0..2 timers, 3 GPIO, 4+2k PWM k A, 5+2k PWM k B (code i+1).
    task automatic pulse_hw(input int i);
        @(negedge clk);
        if (i < 3) tmr_stb[i] = 1;
        else if (i == 3) gpio_stb = 1;
        else if (((i - 4) % 2) == 0) pwm_a_stb[(i - 4) / 2] = 1;
        else pwm_b_stb[(i - 4) / 2] = 1;
        @(negedge clk);
        tmr_stb = 0; gpio_stb = 0; pwm_a_stb = 0; pwm_b_stb = 0;
    endtask

    task automatic pulse_force(input logic [NS-1:0] bits);
        @(negedge clk); force_we = 1; force_bits = bits;
        @(negedge clk); force_we = 0; force_bits = 0;
    endtask

    task automatic pulse_eoc(input logic e1, input logic e2);
        @(negedge clk); eoc1_stb = e1; eoc2_stb = e2;
        @(negedge clk); eoc1_stb = 0; eoc2_stb = 0;
    endtask

    // Accept every offered slot; record set, count, ordering and data.
    task automatic drain();
        int last;
        d_mask = 0; d_cnt = 0; d_order = 1; d_data = 1; last = -1;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (!req_valid) begin req_ready = 0; break; end
            if (int'(req_slot) <= last) d_order = 0;
            last = int'(req_slot);
            if (req_chan != exp_chan[req_slot] || req_win != exp_win[req_slot]) d_data = 0;
            d_mask[req_slot] = 1;
            d_cnt++;
            req_ready = 1;
        end
        req_ready = 0;
    endtask

    initial begin
        logic [NS-1:0] exp;
        do_reset();
        @(negedge clk);
        check(req_valid == 0, "R1 req_valid after reset", req_valid, 0);
        check(idle == 1, "R1 idle after reset", idle, 1);
        check(ovf == 0, "R1 ovf after reset", ovf, 0);
        for (int i = 0; i < NHW; i++) pulse_hw(i);
        @(negedge clk);
        check(req_valid == 0, "R1 code 0 ignores hardware strobes", req_valid, 0);

        // R2 force with software-only codes
        pulse_force(16'h000F);
        drain();
        check(d_mask == 16'h000F && d_cnt == 4, "R2 force queues slots 0..3", d_mask, 16'h000F);
        check(d_order, "R5 ascending order after force", d_order, 1);

        // R3 sweep: slot s holds code s (all 16 codes)
        for (int s = 0; s < NS; s++) write_cfg(s, s, (s * 5 + 3) % 16, s * 31 + 7, 0);
        for (int i = 0; i < NHW; i++) begin
            pulse_hw(i);
            drain();
            exp = NS'(1) << (i + 1);
            check(d_mask == exp && d_cnt == 1, $sformatf("R3 line %0d matches code %0d only", i, i + 1), d_mask, exp);
            check(d_data, "R5 channel and window of offered slot", d_data, 1);
        end
        pulse_force(16'hFFFF);
        drain();
        check(d_mask == 16'hFFFF && d_order && d_data, "R5 full force drain order and data", d_mask, 16'hFFFF);

        // R3 fan-out: slot s uses timer code (s%3)+1
        for (int s = 0; s < NS; s++) write_cfg(s, (s % 3) + 1, s, 500 - s, 0);
        for (int t = 0; t < 3; t++) begin
            exp = 0;
            for (int s = 0; s < NS; s++) if (s % 3 == t) exp[s] = 1;
            pulse_hw(t);
            drain();
            check(d_mask == exp && d_order, $sformatf("R3 timer %0d fan-out", t), d_mask, exp);
        end

        // R4 re-arm: slot s select s%4, code 0
        for (int s = 0; s < NS; s++) write_cfg(s, 0, s, s, s % 4);
        for (int m = 1; m < 4; m++) begin
            exp = 0;
            for (int s = 0; s < NS; s++)
                if (((s % 4) == 3) || ((m & 1) && (s % 4) == 1) || ((m & 2) && (s % 4) == 2)) exp[s] = 1;
            pulse_eoc(m[0], m[1]);
            drain();
            check(d_mask == exp, $sformatf("R4 eoc pattern %0d", m), d_mask, exp);
        end
        check(ovf == 0, "R8 no overflow without repeated trigger", ovf, 0);

        // R7/R8 merge: two timer-0 strobes before any accept
        for (int s = 0; s < NS; s++) write_cfg(s, (s % 3) + 1, s, s, 0);
        pulse_hw(0);
        pulse_hw(0);
        drain();
        exp = 16'b1001001001001001;
        check(d_mask == exp && d_cnt == 6, "R7 merged triggers offered once", d_cnt, 6);
        check(ovf == exp, "R8 overflow on repeated trigger", ovf, exp);
        pulse_hw(1);
        drain();
        check(ovf == exp, "R8 overflow sticky", ovf, exp);

        // R9 idle
        pulse_force(16'h0100);
        check(idle == 0 && req_valid == 1 && req_slot == 8, "R9 idle low while pending", idle, 0);
        drain();
        @(negedge clk); conv_busy = 1;
        @(negedge clk);
        check(idle == 0, "R9 idle low while converter busy", idle, 0);
        conv_busy = 0;
        @(negedge clk);
        check(idle == 1, "R9 idle high when quiet", idle, 1);

        // R6 accept and R10 re-trigger in accept cycle
        do_reset();
        pulse_force(16'h0028);
        @(negedge clk);
        check(req_valid && req_slot == 3, "R5 lowest of slots 3 and 5", req_slot, 3);
        req_ready = 1; force_we = 1; force_bits = 16'h0008;
        @(negedge clk);
        req_ready = 0; force_we = 0; force_bits = 0;
        check(req_valid && req_slot == 3, "R10 slot requeued in accept cycle", req_slot, 3);
        check(ovf == 0, "R10 no overflow in accept cycle", ovf, 0);
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        check(req_valid && req_slot == 5, "R6 accept moves to next slot", req_slot, 5);
        drain();
        check(d_mask == 16'h0020 && d_cnt == 1, "R6 remaining slot once", d_mask, 16'h0020);
        @(negedge clk);
        check(req_valid == 0, "R6 nothing left", req_valid, 0);

        finish_run();
    end

endmodule